// File: doc/BRIEF.md
# LCD window and orientation command generator

This block sits between a display-update engine and the serial link of a small TFT panel controller. It takes one of three requests: set a drawing window, set the panel orientation, or load the gamma curves. For each request it produces the matching run of 9-bit words. Bit 8 of each word is the data/command flag and bits 7:0 are the byte. A downstream shifter takes the words over a valid/ready handshake.

A window request carries four corner coordinates. The block puts each start/end pair in order and sends the column window, then the row window, then the memory-write opener. An orientation request turns a rotation code and a colour-order select into one address-mode byte. A gamma request reads two curves of parameters from an external table through a combinational index/value port.

While a sequence is in flight, `busy_o` is high and new requests are dropped. The native panel is 240 columns by 320 rows. The block does not clip coordinates to that size.

Top module: `lcd_cmd_gen`

## Requirements
- R1: After reset, `busy_o`, `word_valid_o` and `rot_err_o` are 0.
- R2: Each word has bit 8 = 0 for a command byte and bit 8 = 1 for a parameter byte. A window request emits exactly 11 words:
  - command 0x2A, then x start high, x start low, x end high, x end low;
  - command 0x2B, then the same four-byte layout for y;
  - command 0x2C with no parameters.
- R3: If a start coordinate is greater than its end coordinate, the two values of that axis are swapped before sending. Equal values are sent unchanged.
- R4: An orientation request emits command 0x36 and then one parameter byte. Rotation code 0 (0 deg) gives 0x40, code 1 (90 deg) gives 0xE0, code 2 (180 deg) gives 0x80, and code 3 (270 deg) gives 0x30. If `bgr_i` is set, bit 3 of the byte is also set.
- R5: Rotation codes 4 to 7 produce no words. `rot_err_o` goes high for exactly one cycle, in the cycle after the request is taken.
- R6: A gamma request emits command 0xE0 followed by 15 parameters, then command 0xE1 followed by 15 parameters. Parameter k of curve c is `gam_val_i` while `gam_idx_o` = c*15+k.
- R7: A word stays valid and unchanged while `word_ready_i` is low. The block moves to the next word only on a cycle where valid and ready are both high.
- R8: A request that arrives while `busy_o` is high is ignored. No words from it ever appear.
- R9: If several requests arrive together while idle, only one is served. Window wins over orientation, and orientation wins over gamma.
- R10: The first word of an accepted sequence is valid in the cycle after the request. `busy_o` falls in the cycle after the last word is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_req_i | input | 1 | Window request pulse |
| x_start_i | input | 16 | Column start coordinate |
| y_start_i | input | 16 | Row start coordinate |
| x_end_i | input | 16 | Column end coordinate |
| y_end_i | input | 16 | Row end coordinate |
| ori_req_i | input | 1 | Orientation request pulse |
| rot_i | input | 3 | Rotation code (0..3 valid) |
| bgr_i | input | 1 | Colour-order select |
| gam_req_i | input | 1 | Gamma load request pulse |
| gam_idx_o | output | 5 | Gamma table read index |
| gam_val_i | input | 8 | Gamma table value at `gam_idx_o` |
| word_o | output | 9 | Output word, bit 8 = data flag |
| word_valid_o | output | 1 | Output word valid |
| word_ready_i | input | 1 | Downstream ready |
| busy_o | output | 1 | Sequence in progress |
| rot_err_o | output | 1 | One-cycle pulse for an unknown rotation code |

## Verification
The bench builds the block with its default parameters: 16-bit coordinates, two gamma curves and 15 parameters per curve. At these values every coordinate byte matters, so high bytes above 0x00 and values past the 240/320 panel size are driven on purpose. Each gamma index reaches the top of the 30-entry table. Randomly stalled `word_ready_i` exercises holding a word at every position in each sequence, including the final memory-write command and the group boundaries between curves.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_WIN, OP_ORI, OP_GAM} op_e;

  localparam logic [7:0] CMD_COL_WIN  = 8'h2A;
  localparam logic [7:0] CMD_ROW_WIN  = 8'h2B;
  localparam logic [7:0] CMD_MEM_WR   = 8'h2C;
  localparam logic [7:0] CMD_ADR_MODE = 8'h36;
  localparam logic [7:0] CMD_GAM_BASE = 8'hE0;

  // address-mode bit positions
  localparam int unsigned AM_ROW_ORD = 7;
  localparam int unsigned AM_COL_ORD = 6;
  localparam int unsigned AM_XCHG    = 5;
  localparam int unsigned AM_VREF    = 4;
  localparam int unsigned AM_BGR     = 3;
  localparam int unsigned AM_HREF    = 2;
endpackage

// File: rtl/lcd_orient_enc.sv
module lcd_orient_enc
  import lcd_cmd_pkg::*;
(
  input  logic [2:0] rot_i,
  input  logic       bgr_i,
  output logic [7:0] mode_o,
  output logic       known_o
);
  logic [7:0] base;

  always_comb begin
    base    = '0;
    known_o = 1'b1;
    unique case (rot_i)
      3'd0: base[AM_COL_ORD] = 1'b1;
      3'd1: begin
        base[AM_ROW_ORD] = 1'b1;
        base[AM_COL_ORD] = 1'b1;
        base[AM_XCHG]    = 1'b1;
      end
      3'd2: base[AM_ROW_ORD] = 1'b1;
      3'd3: begin
        base[AM_XCHG] = 1'b1;
        base[AM_VREF] = 1'b1;
      end
      default: known_o = 1'b0;
    endcase
    mode_o = base | (8'(bgr_i) << AM_BGR);
  end
endmodule

// File: rtl/lcd_win_norm.sv
module lcd_win_norm #(
  parameter int unsigned CW = 16
) (
  input  logic [CW-1:0] a_i,
  input  logic [CW-1:0] b_i,
  output logic [CW-1:0] lo_o,
  output logic [CW-1:0] hi_o
);
  logic swap;
  assign swap = a_i > b_i;
  assign lo_o = swap ? b_i : a_i;
  assign hi_o = swap ? a_i : b_i;
endmodule

// File: rtl/lcd_word_seq.sv
module lcd_word_seq
  import lcd_cmd_pkg::*;
#(
  parameter int unsigned CW         = 16,
  parameter int unsigned GAM_N      = 15,
  parameter int unsigned GAM_CURVES = 2,
  localparam int unsigned CB  = CW / 8,
  localparam int unsigned GIW = $clog2(GAM_N * GAM_CURVES),
  localparam int unsigned GW  = (GAM_CURVES > 3) ? $clog2(GAM_CURVES) : 2,
  localparam int unsigned WLEN = 1 + 2 * CB,
  localparam int unsigned MAXLEN = (WLEN > GAM_N + 1) ? WLEN : GAM_N + 1,
  localparam int unsigned PW  = $clog2(MAXLEN + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  op_e            start_op_i,
  input  logic [CW-1:0]  xs_i,
  input  logic [CW-1:0]  xe_i,
  input  logic [CW-1:0]  ys_i,
  input  logic [CW-1:0]  ye_i,
  input  logic [7:0]     mode_i,
  output logic [GIW-1:0] gam_idx_o,
  input  logic [7:0]     gam_val_i,
  output logic [8:0]     word_o,
  output logic           word_valid_o,
  input  logic           word_ready_i,
  output logic           busy_o
);
  op_e           op_q;
  logic [GW-1:0] grp_q;
  logic [PW-1:0] pos_q;
  logic [CW-1:0] xs_q, xe_q, ys_q, ye_q;
  logic [7:0]    mode_q;

  logic [PW-1:0] grp_len;
  logic [GW-1:0] grp_last;
  logic          fire, pos_end;

  always_comb begin
    grp_len  = PW'(1);
    grp_last = '0;
    unique case (op_q)
      OP_WIN: begin
        grp_len  = (grp_q == GW'(2)) ? PW'(1) : PW'(WLEN);
        grp_last = GW'(2);
      end
      OP_ORI: grp_len = PW'(2);
      OP_GAM: begin
        grp_len  = PW'(GAM_N + 1);
        grp_last = GW'(GAM_CURVES - 1);
      end
      default: ;
    endcase
  end

  assign fire    = (op_q != OP_IDLE) && word_ready_i;
  assign pos_end = (pos_q == grp_len - PW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      grp_q  <= '0;
      pos_q  <= '0;
      xs_q   <= '0;
      xe_q   <= '0;
      ys_q   <= '0;
      ye_q   <= '0;
      mode_q <= '0;
    end else if (op_q == OP_IDLE) begin
      if (start_op_i != OP_IDLE) begin
        op_q   <= start_op_i;
        grp_q  <= '0;
        pos_q  <= '0;
        xs_q   <= xs_i;
        xe_q   <= xe_i;
        ys_q   <= ys_i;
        ye_q   <= ye_i;
        mode_q <= mode_i;
      end
    end else if (fire) begin
      if (pos_end) begin
        pos_q <= '0;
        if (grp_q == grp_last) op_q <= OP_IDLE;
        else                   grp_q <= grp_q + GW'(1);
      end else begin
        pos_q <= pos_q + PW'(1);
      end
    end
  end

  // coordinate byte pick, most significant byte first
  logic [CW-1:0] crd;
  logic [7:0]    crd_byte;
  int unsigned   pidx, bidx;

  always_comb begin
    pidx = (pos_q == '0) ? 0 : int'(pos_q) - 1;
    bidx = (pidx < CB) ? pidx : pidx - CB;
    if (grp_q == '0) crd = (pidx < CB) ? xs_q : xe_q;
    else             crd = (pidx < CB) ? ys_q : ye_q;
    crd_byte = 8'(crd >> (8 * (CB - 1 - bidx)));
  end

  int gidx;
  always_comb begin
    gidx = int'(grp_q) * int'(GAM_N) + int'(pos_q) - 1;
    gam_idx_o = (op_q == OP_GAM && pos_q != '0) ? GIW'(gidx) : '0;
  end

  always_comb begin
    word_o = '0;
    unique case (op_q)
      OP_WIN: begin
        if (pos_q == '0) begin
          unique case (grp_q)
            GW'(0):  word_o = {1'b0, CMD_COL_WIN};
            GW'(1):  word_o = {1'b0, CMD_ROW_WIN};
            default: word_o = {1'b0, CMD_MEM_WR};
          endcase
        end else begin
          word_o = {1'b1, crd_byte};
        end
      end
      OP_ORI: word_o = (pos_q == '0) ? {1'b0, CMD_ADR_MODE} : {1'b1, mode_q};
      OP_GAM: word_o = (pos_q == '0) ? {1'b0, CMD_GAM_BASE + 8'(grp_q)}
                                     : {1'b1, gam_val_i};
      default: ;
    endcase
  end

  assign word_valid_o = (op_q != OP_IDLE);
  assign busy_o       = word_valid_o;
endmodule

// File: rtl/lcd_cmd_gen.sv
module lcd_cmd_gen
  import lcd_cmd_pkg::*;
#(
  parameter int unsigned CW         = 16,
  parameter int unsigned GAM_N      = 15,
  parameter int unsigned GAM_CURVES = 2,
  localparam int unsigned GIW = $clog2(GAM_N * GAM_CURVES)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           win_req_i,
  input  logic [CW-1:0]  x_start_i,
  input  logic [CW-1:0]  y_start_i,
  input  logic [CW-1:0]  x_end_i,
  input  logic [CW-1:0]  y_end_i,
  input  logic           ori_req_i,
  input  logic [2:0]     rot_i,
  input  logic           bgr_i,
  input  logic           gam_req_i,
  output logic [GIW-1:0] gam_idx_o,
  input  logic [7:0]     gam_val_i,
  output logic [8:0]     word_o,
  output logic           word_valid_o,
  input  logic           word_ready_i,
  output logic           busy_o,
  output logic           rot_err_o
);
  logic [CW-1:0] a_in [2], b_in [2], lo [2], hi [2];
  assign a_in[0] = x_start_i;
  assign b_in[0] = x_end_i;
  assign a_in[1] = y_start_i;
  assign b_in[1] = y_end_i;

  for (genvar g = 0; g < 2; g++) begin : g_axis
    lcd_win_norm #(.CW(CW)) u_norm (
      .a_i (a_in[g]),
      .b_i (b_in[g]),
      .lo_o(lo[g]),
      .hi_o(hi[g])
    );
  end

  logic [7:0] mode;
  logic       rot_ok;
  lcd_orient_enc u_enc (
    .rot_i  (rot_i),
    .bgr_i  (bgr_i),
    .mode_o (mode),
    .known_o(rot_ok)
  );

  logic seq_busy, idle, bad_rot;
  op_e  start_op;

  assign idle    = !seq_busy;
  assign bad_rot = idle && !win_req_i && ori_req_i && !rot_ok;

  always_comb begin
    start_op = OP_IDLE;
    if (idle) begin
      if (win_req_i)                 start_op = OP_WIN;
      else if (ori_req_i && rot_ok)  start_op = OP_ORI;
      else if (!ori_req_i && gam_req_i) start_op = OP_GAM;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rot_err_o <= 1'b0;
    else         rot_err_o <= bad_rot;
  end

  lcd_word_seq #(.CW(CW), .GAM_N(GAM_N), .GAM_CURVES(GAM_CURVES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_op_i  (start_op),
    .xs_i        (lo[0]),
    .xe_i        (hi[0]),
    .ys_i        (lo[1]),
    .ye_i        (hi[1]),
    .mode_i      (mode),
    .gam_idx_o   (gam_idx_o),
    .gam_val_i   (gam_val_i),
    .word_o      (word_o),
    .word_valid_o(word_valid_o),
    .word_ready_i(word_ready_i),
    .busy_o      (seq_busy)
  );

  assign busy_o = seq_busy;
endmodule

// File: rtl/lcd_cmd_gen_chk.sv
module lcd_cmd_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       win_req_i,
  input logic       ori_req_i,
  input logic [2:0] rot_i,
  input logic [8:0] word_o,
  input logic       word_valid_o,
  input logic       word_ready_i,
  input logic       busy_o,
  input logic       rot_err_o
);
  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |=> word_valid_o && $stable(word_o));

  // R5
  err_no_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rot_err_o |-> !word_valid_o);

  // R2
  win_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && win_req_i |=> word_valid_o && word_o == 9'h02A);

  // R4
  ori_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !win_req_i && ori_req_i && !rot_i[2] |=> word_valid_o && word_o == 9'h036);

  // R10
  memwr_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && word_ready_i && word_o == 9'h02C |=> !busy_o);
endmodule

bind lcd_cmd_gen lcd_cmd_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .win_req_i   (win_req_i),
  .ori_req_i   (ori_req_i),
  .rot_i       (rot_i),
  .word_o      (word_o),
  .word_valid_o(word_valid_o),
  .word_ready_i(word_ready_i),
  .busy_o      (busy_o),
  .rot_err_o   (rot_err_o)
);

// File: tb/sim_lcd_cmd_gen.sv
`timescale 1ns/1ps
module sim_lcd_cmd_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        win_req_i = 0, ori_req_i = 0, gam_req_i = 0, bgr_i = 0;
  logic [15:0] x_start_i = 0, y_start_i = 0, x_end_i = 0, y_end_i = 0;
  logic [2:0]  rot_i = 0;
  logic [4:0]  gam_idx_o;
  logic [7:0]  gam_val_i;
  logic [8:0]  word_o;
  logic        word_valid_o, word_ready_i = 0, busy_o, rot_err_o;

  int checks = 0, fails = 0;
  logic [8:0] exp_w [64];
  int exp_n;

  always #5 clk_i = ~clk_i;

  function automatic logic [7:0] gtab(int i);
    return 8'((i * 37 + 5) & 8'hFF);
  endfunction
  assign gam_val_i = gtab(int'(gam_idx_o));

  lcd_cmd_gen u0 (.*);

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] mode_of(int r, bit b);
    logic [7:0] m;
    case (r)
      0: m = 8'h40;
      1: m = 8'hE0;
      2: m = 8'h80;
      default: m = 8'h30;
    endcase
    return m | (b ? 8'h08 : 8'h00);
  endfunction

  task automatic exp_win(logic [15:0] xs, logic [15:0] ys, logic [15:0] xe, logic [15:0] ye);
    logic [15:0] t;
    if (xs > xe) begin t = xs; xs = xe; xe = t; end  // R3
    if (ys > ye) begin t = ys; ys = ye; ye = t; end
    exp_w[0] = 9'h02A; exp_w[1] = {1'b1, xs[15:8]}; exp_w[2] = {1'b1, xs[7:0]};
    exp_w[3] = {1'b1, xe[15:8]}; exp_w[4] = {1'b1, xe[7:0]};
    exp_w[5] = 9'h02B; exp_w[6] = {1'b1, ys[15:8]}; exp_w[7] = {1'b1, ys[7:0]};
    exp_w[8] = {1'b1, ye[15:8]}; exp_w[9] = {1'b1, ye[7:0]};
    exp_w[10] = 9'h02C; exp_n = 11;
  endtask

  task automatic exp_gam();
    exp_n = 0;
    for (int c = 0; c < 2; c++) begin
      exp_w[exp_n++] = {1'b0, 8'hE0 + 8'(c)};
      for (int k = 0; k < 15; k++) exp_w[exp_n++] = {1'b1, gtab(c * 15 + k)};
    end
  endtask

  task automatic pulse(bit w, bit o, bit g);
    @(negedge clk_i);
    win_req_i = w; ori_req_i = o; gam_req_i = g;
    @(negedge clk_i);
    win_req_i = 0; ori_req_i = 0; gam_req_i = 0;
  endtask

  // collects exp_n words under random ready, then checks idle
  task automatic drain(string rq, bit poke);
    int got = 0;
    bit held = 0;
    logic [8:0] hw = '0;
    int guard = 0;
    while (got < exp_n && guard < 1000) begin
      bit r;
      guard++;
      @(negedge clk_i);
      r = ($urandom % 4) != 0;
      word_ready_i = r;
      if (poke && got == 3) begin ori_req_i = 1; gam_req_i = 1; end  // R8
      else begin ori_req_i = 0; gam_req_i = 0; end
      #1;
      if (held) chk("R7 hold", {23'd0, word_valid_o, word_o}, {23'd0, 1'b1, hw});
      held = word_valid_o && !r;
      hw = word_o;
      if (word_valid_o && r) begin
        chk(rq, {23'd0, word_o}, {23'd0, exp_w[got]});
        got++;
      end
    end
    @(negedge clk_i);
    word_ready_i = 0; ori_req_i = 0; gam_req_i = 0;
    chk("R10 idle after last", {30'd0, busy_o, word_valid_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    chk("R8 no extra words", {31'd0, word_valid_o}, 32'd0);
  endtask

  task automatic do_win(logic [15:0] xs, logic [15:0] ys, logic [15:0] xe, logic [15:0] ye, bit poke);
    x_start_i = xs; y_start_i = ys; x_end_i = xe; y_end_i = ye;
    exp_win(xs, ys, xe, ye);
    pulse(1, 0, 0);
    chk("R10 first word", {23'd0, word_valid_o, word_o}, {23'd0, 1'b1, 9'h02A});
    drain("R2 window word", poke);
  endtask

  task automatic do_ori(int r, bit b);
    rot_i = 3'(r); bgr_i = b;
    pulse(0, 1, 0);
    if (r > 3) begin
      chk("R5 err pulse", {30'd0, rot_err_o, word_valid_o}, 32'd2);
      @(negedge clk_i);
      chk("R5 err one cycle", {30'd0, rot_err_o, word_valid_o}, 32'd0);
    end else begin
      exp_w[0] = 9'h036; exp_w[1] = {1'b1, mode_of(r, b)}; exp_n = 2;
      drain("R4 orient word", 0);
    end
  endtask

  task automatic do_gam();
    exp_gam();
    pulse(0, 0, 1);
    drain("R6 gamma word", 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("R1 reset", {29'd0, busy_o, word_valid_o, rot_err_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 after release", {29'd0, busy_o, word_valid_o, rot_err_o}, 32'd0);

    do_win(16'd0, 16'd0, 16'd239, 16'd319, 0);
    do_win(16'd300, 16'd50, 16'd10, 16'd50, 0);       // R3 swap x, equal y
    do_win(16'hABCD, 16'hFFFF, 16'h1234, 16'h0000, 1); // R3 swap both, R8 poke
    for (int r = 0; r < 8; r++) do_ori(r, r[0]);
    do_ori(3, 1);
    do_gam();

    // R9 priority
    x_start_i = 16'd5; y_start_i = 16'd6; x_end_i = 16'd7; y_end_i = 16'd8;
    exp_win(16'd5, 16'd6, 16'd7, 16'd8);
    rot_i = 0;
    pulse(1, 1, 1);
    drain("R9 window wins", 0);
    exp_w[0] = 9'h036; exp_w[1] = {1'b1, mode_of(2, 0)}; exp_n = 2;
    rot_i = 2; bgr_i = 0;
    pulse(0, 1, 1);
    drain("R9 orient over gamma", 0);

    for (int i = 0; i < 30; i++) begin
      int k = $urandom % 3;
      if (k == 0) do_win(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), 0);
      else if (k == 1) do_ori($urandom % 8, 1'($urandom));
      else do_gam();
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule